// File: doc/BRIEF.md
# Registered Configurable Parallel Multiplier

This block multiplies two 16-bit operands and presents the product through registered, reformattable output halves. Each operand is held in its own register, loaded by its own enable together with a per-operand sign-mode bit, so signed, unsigned and mixed-sign products are all supported. A round request is captured alongside the operands. When it is set, the product is rounded to 16-bit precision before it is split into halves.

The product is formatted either as a full 32-bit value or as a 31-bit value whose sign is repeated in the top bit of the lower half. The two halves are held in separate result registers with independent load enables. A feed-through control bypasses both result registers. An upper output port carries either half, under a select line. The lower half can also be driven back onto the bidirectional B operand port. Both output ports have their own output enable and float when disabled. All state runs on one clock, and the load enables stand in for separate register clocks.

Top module: `pm_mult`

## Requirements
- R1: On a clock edge with `ld_a` high, the A register takes `a_in` and `a_tc`. With `ld_a` low, it keeps its contents whatever `a_in` does.
- R2: On a clock edge with `ld_b` high, the B register takes the value on `b_io` and `b_tc`. With `ld_b` low, it keeps its contents.
- R3: A sign-mode bit of 1 makes its operand two's complement, and 0 makes it unsigned. The two bits act independently, and the product is the exact 32-bit result for all four mode pairs.
- R4: The round flag takes `rnd_in` on every edge where `ld_a` or `ld_b` is high, and holds otherwise. When the flag is set, one is added at the bit that becomes the top of the lower half. That is product bit 15 when `rs`=1 and bit 14 when `rs`=0.
- R5: With `rs`=1, the upper half is product bits 31..16 and the lower half is bits 15..0. With `rs`=0, the upper half is bits 30..15 and the lower half is {bit 31, bits 14..0}.
- R6: The upper result register loads the formatted upper half on an edge with `ld_hi` high. The lower result register loads the formatted lower half on an edge with `ld_lo` high. Each register holds otherwise, independently of the other.
- R7: With `ft`=1, both halves show the formatted result of the current operand registers in the same cycle, bypassing the result registers.
- R8: With `oe_hi`=1, `hi_y` carries the upper half when `msel`=0 and the lower half when `msel`=1. With `oe_hi`=0, `hi_y` is high impedance.
- R9: With `oe_lo`=1, the block drives the lower half onto `b_io`. With `oe_lo`=0, the block leaves `b_io` undriven so that an external source can load B.
- R10: An active-low `rst_n` clears both operand registers, both sign-mode bits, the round flag and both result registers to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_a | input | 1 | Load enable for operand A, its mode bit and the round flag |
| a_in | input | 16 | Operand A data |
| a_tc | input | 1 | Operand A mode: 1 two's complement, 0 unsigned |
| ld_b | input | 1 | Load enable for operand B, its mode bit and the round flag |
| b_tc | input | 1 | Operand B mode: 1 two's complement, 0 unsigned |
| b_io | inout | 16 | Operand B input; lower result half output when `oe_lo`=1 |
| rnd_in | input | 1 | Round request |
| rs | input | 1 | Format: 1 full 32-bit, 0 31-bit with sign copy |
| ld_hi | input | 1 | Load enable of the upper result register |
| ld_lo | input | 1 | Load enable of the lower result register |
| ft | input | 1 | Feed-through: bypass both result registers |
| msel | input | 1 | Upper port select: 0 upper half, 1 lower half |
| oe_hi | input | 1 | Output enable of `hi_y` |
| oe_lo | input | 1 | Output enable of the lower half on `b_io` |
| hi_y | output | 16 | Upper output port |

## Verification
A corrupted operand register or round flag shows at the ports in the cycle right after the next result load. With feed-through set, it shows in the cycle after the bad capture. Each such fault moves the whole product or a rounding carry into both halves. A wrong format or rounding position only moves the bits around bit 15 and the sign copy, so values near half scale and the most negative operands are the patterns that expose it. A result register that loads when its enable is low shows on its own half only, and only once the other half is loaded while this one is held.

// File: rtl/pm_pkg.sv
package pm_pkg;

  // output format choice driven by rs
  typedef enum logic {
    FMT_SIGNCOPY = 1'b0,
    FMT_FULL     = 1'b1
  } pm_fmt_e;

  // half routed to the upper port
  typedef enum logic {
    SEL_UPPER = 1'b0,
    SEL_LOWER = 1'b1
  } pm_sel_e;

  // index of each half in the result arrays
  localparam int unsigned HALF_LO = 0;
  localparam int unsigned HALF_HI = 1;
  localparam int unsigned N_HALF  = 2;

endpackage

// File: rtl/pm_opreg.sv
module pm_opreg #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [W-1:0] d,
  input  logic         tc_d,
  output logic [W-1:0] q,
  output logic         tc_q
);

  // operand value and its sign mode are captured as one unit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q    <= '0;
      tc_q <= 1'b0;
    end else if (ld) begin
      q    <= d;
      tc_q <= tc_d;
    end
  end

endmodule

// File: rtl/pm_arith.sv
module pm_arith
  import pm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0]   a,
  input  logic           a_tc,
  input  logic [W-1:0]   b,
  input  logic           b_tc,
  input  logic           rnd,
  input  logic           rs,
  output logic [2*W-1:0] prod_raw,
  output logic [2*W-1:0] prod_rnd,
  output logic [W-1:0]   fmt_hi,
  output logic [W-1:0]   fmt_lo
);

  localparam int unsigned PW = 2 * W;
  localparam int unsigned XW = PW + 2;

  // widen an operand to the product width, sign-filling only in two's complement mode
  function automatic logic signed [XW-1:0] f_widen(input logic [W-1:0] x, input logic tc);
    logic fill;
    fill = tc & x[W-1];
    return {{(XW-W){fill}}, x};
  endfunction

  // exact product, kept to PW bits
  function automatic logic [PW-1:0] f_mul(input logic [W-1:0] x, input logic xt,
                                          input logic [W-1:0] y, input logic yt);
    logic signed [XW-1:0] sx, sy, pp;
    sx = f_widen(x, xt);
    sy = f_widen(y, yt);
    pp = sx * sy;
    return pp[PW-1:0];
  endfunction

  // rounding constant lands on the bit that ends up as the top of the lower half
  function automatic logic [PW-1:0] f_rcon(input logic en, input logic full);
    logic [PW-1:0] c;
    c = '0;
    c[W-1] = en & full;
    c[W-2] = en & ~full;
    return c;
  endfunction

  // split into {upper, lower} under the chosen format
  function automatic logic [PW-1:0] f_fmt(input logic [PW-1:0] p, input logic full);
    logic [PW-1:0] r;
    if (full == FMT_FULL) r = p;
    else                  r = {p[PW-2:W-1], p[PW-1], p[W-2:0]};
    return r;
  endfunction

  logic [PW-1:0] fmt_word;

  always_comb begin
    prod_raw = f_mul(a, a_tc, b, b_tc);
    prod_rnd = prod_raw + f_rcon(rnd, rs);
    fmt_word = f_fmt(prod_rnd, rs);
    fmt_hi   = fmt_word[PW-1:W];
    fmt_lo   = fmt_word[W-1:0];
  end

endmodule

// File: rtl/pm_half.sv
module pm_half #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic         ft,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic [W-1:0] y
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (ld) q <= d;
  end

  // transparent path when feed-through is set
  assign y = ft ? d : q;

endmodule

// File: rtl/pm_mult.sv
module pm_mult
  import pm_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_a,
  input  logic [W-1:0] a_in,
  input  logic         a_tc,
  input  logic         ld_b,
  input  logic         b_tc,
  inout  wire  [W-1:0] b_io,
  input  logic         rnd_in,
  input  logic         rs,
  input  logic         ld_hi,
  input  logic         ld_lo,
  input  logic         ft,
  input  logic         msel,
  input  logic         oe_hi,
  input  logic         oe_lo,
  output logic [W-1:0] hi_y
);

  localparam int unsigned PW = 2 * W;

  // named internal events, used by the bound checker
  logic [W-1:0]  a_q, b_q;
  logic          a_tc_q, b_tc_q;
  logic          rnd_q;
  logic          rnd_ld;
  logic [PW-1:0] prod_raw, prod_rnd;
  logic [W-1:0]  fmt_hi, fmt_lo;
  logic [W-1:0]  hi_reg, lo_reg;
  logic [W-1:0]  hi_res, lo_res;
  logic [W-1:0]  port_val;

  pm_opreg #(.W(W)) u_opa (
    .clk(clk), .rst_n(rst_n), .ld(ld_a), .d(a_in), .tc_d(a_tc),
    .q(a_q), .tc_q(a_tc_q)
  );

  pm_opreg #(.W(W)) u_opb (
    .clk(clk), .rst_n(rst_n), .ld(ld_b), .d(b_io), .tc_d(b_tc),
    .q(b_q), .tc_q(b_tc_q)
  );

  // round request follows either operand load
  assign rnd_ld = ld_a | ld_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rnd_q <= 1'b0;
    else if (rnd_ld) rnd_q <= rnd_in;
  end

  pm_arith #(.W(W)) u_arith (
    .a(a_q), .a_tc(a_tc_q), .b(b_q), .b_tc(b_tc_q),
    .rnd(rnd_q), .rs(rs),
    .prod_raw(prod_raw), .prod_rnd(prod_rnd),
    .fmt_hi(fmt_hi), .fmt_lo(fmt_lo)
  );

  // two result halves, each with its own load and a shared bypass
  logic [N_HALF-1:0]        half_ld;
  logic [N_HALF-1:0][W-1:0] half_d, half_q, half_y;

  assign half_ld[HALF_HI] = ld_hi;
  assign half_ld[HALF_LO] = ld_lo;
  assign half_d[HALF_HI]  = fmt_hi;
  assign half_d[HALF_LO]  = fmt_lo;

  for (genvar g = 0; g < N_HALF; g++) begin : g_half
    pm_half #(.W(W)) u_half (
      .clk(clk), .rst_n(rst_n), .ld(half_ld[g]), .ft(ft),
      .d(half_d[g]), .q(half_q[g]), .y(half_y[g])
    );
  end

  assign hi_reg = half_q[HALF_HI];
  assign lo_reg = half_q[HALF_LO];
  assign hi_res = half_y[HALF_HI];
  assign lo_res = half_y[HALF_LO];

  // upper port multiplexer and three-state drivers
  assign port_val = (msel == SEL_LOWER) ? lo_res : hi_res;
  assign hi_y     = oe_hi ? port_val : {W{1'bz}};
  assign b_io     = oe_lo ? lo_res : {W{1'bz}};

endmodule

// File: rtl/pm_mult_chk.sv
module pm_mult_chk #(
  parameter int unsigned W = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ld_a,
  input logic [W-1:0]   a_in,
  input logic           a_tc,
  input logic           ld_b,
  input logic           b_tc,
  input logic [W-1:0]   b_io,
  input logic           rnd_in,
  input logic           rs,
  input logic           ld_hi,
  input logic           ld_lo,
  input logic           ft,
  input logic           msel,
  input logic           oe_hi,
  input logic           oe_lo,
  input logic [W-1:0]   hi_y,
  input logic [W-1:0]   a_q,
  input logic [W-1:0]   b_q,
  input logic           a_tc_q,
  input logic           b_tc_q,
  input logic           rnd_q,
  input logic [2*W-1:0] prod_rnd,
  input logic [W-1:0]   fmt_hi,
  input logic [W-1:0]   fmt_lo,
  input logic [W-1:0]   hi_reg,
  input logic [W-1:0]   lo_reg,
  input logic [W-1:0]   hi_res,
  input logic [W-1:0]   lo_res
);

  p_opa_load_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (a_q == $past(a_in) && a_tc_q == $past(a_tc)));

  p_opa_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_a |=> ($stable(a_q) && $stable(a_tc_q)));

  p_opb_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ld_b |=> (b_q == $past(b_io) && b_tc_q == $past(b_tc)));

  p_opb_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_b |=> ($stable(b_q) && $stable(b_tc_q)));

  p_rnd_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a || ld_b) |=> (rnd_q == $past(rnd_in)));

  p_rnd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_a || ld_b) |=> $stable(rnd_q));

  p_sign_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !rs |-> (fmt_lo[W-1] == prod_rnd[2*W-1]));

  p_hi_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ld_hi |=> (hi_reg == $past(fmt_hi)));

  p_hi_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_hi |=> $stable(hi_reg));

  p_lo_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_lo |=> $stable(lo_reg));

  p_ft_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ft |-> (hi_res == fmt_hi && lo_res == fmt_lo));

  p_mux_lower_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi && msel) |-> (hi_y == lo_res));

  p_mux_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (oe_hi && !msel) |-> (hi_y == hi_res));

  p_bus_drive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    oe_lo |-> (b_io == lo_res));

  p_reset_r10: assert property (@(posedge clk)
    !rst_n |=> (a_q == '0 && b_q == '0 && !rnd_q && hi_reg == '0 && lo_reg == '0));

endmodule

bind pm_mult pm_mult_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .a_in(a_in), .a_tc(a_tc),
  .ld_b(ld_b), .b_tc(b_tc), .b_io(b_io), .rnd_in(rnd_in), .rs(rs),
  .ld_hi(ld_hi), .ld_lo(ld_lo), .ft(ft), .msel(msel), .oe_hi(oe_hi),
  .oe_lo(oe_lo), .hi_y(hi_y), .a_q(a_q), .b_q(b_q), .a_tc_q(a_tc_q),
  .b_tc_q(b_tc_q), .rnd_q(rnd_q), .prod_rnd(prod_rnd), .fmt_hi(fmt_hi),
  .fmt_lo(fmt_lo), .hi_reg(hi_reg), .lo_reg(lo_reg), .hi_res(hi_res),
  .lo_res(lo_res)
);

// File: tb/pm_mult_tb.sv
module pm_mult_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ld_a = 1'b0, a_tc = 1'b0, ld_b = 1'b0, b_tc = 1'b0;
  logic [15:0] a_in = '0;
  logic [15:0] tb_b = '0;
  logic        tb_b_en = 1'b0;
  logic        rnd_in = 1'b0, rs = 1'b1, ld_hi = 1'b0, ld_lo = 1'b0;
  logic        ft = 1'b0, msel = 1'b0, oe_hi = 1'b0, oe_lo = 1'b0;
  wire  [15:0] b_bus;
  logic [15:0] hi_y;

  assign b_bus = tb_b_en ? tb_b : 16'bz;

  always #5 clk = ~clk;

  pm_mult u_dut (
    .clk(clk), .rst_n(rst_n), .ld_a(ld_a), .a_in(a_in), .a_tc(a_tc),
    .ld_b(ld_b), .b_tc(b_tc), .b_io(b_bus), .rnd_in(rnd_in), .rs(rs),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ft(ft), .msel(msel), .oe_hi(oe_hi),
    .oe_lo(oe_lo), .hi_y(hi_y)
  );

  typedef struct {
    logic [15:0] hi;
    logic [15:0] lo;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   n_chk = 0;
  int   n_bad = 0;
  logic smp = 1'b0;
  logic done = 1'b0;

  // bench-side picture of the registers, built from the requirements
  logic [15:0] m_a = '0, m_b = '0, m_hi = '0, m_lo = '0;
  logic        m_ta = 1'b0, m_tb = 1'b0, m_rnd = 1'b0;

  // expected {upper, lower}: integer product, rounding weight, then bit shuffle
  function automatic logic [31:0] ref_word();
    longint av, bv, pv;
    logic [31:0] w;
    av = m_ta ? longint'($signed(m_a)) : longint'({16'd0, m_a});
    bv = m_tb ? longint'($signed(m_b)) : longint'({16'd0, m_b});
    pv = av * bv;
    if (m_rnd) pv = pv + (rs ? 64'sd32768 : 64'sd16384);
    w = pv[31:0];
    if (rs) return w;
    return {w[30:15], w[31], w[14:0]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [15:0] act,
                     input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  // monitor: pops one expected item per sample slot
  initial begin
    exp_t it;
    forever begin
      @(posedge clk);
      #3;
      if (smp) begin
        if (sb_q.size() == 0) begin
          n_chk++; n_bad++;
          $display("FAIL R8 scoreboard act=empty exp=item");
        end else begin
          it = sb_q.pop_front();
          chk(it.tag, "hi_y", hi_y, it.hi);
          chk(it.tag, "b_io", b_bus, it.lo);
        end
      end
    end
  end

  // driver tasks: entered and left at a falling edge
  task automatic load_ops(input logic [15:0] a, input logic ta, input logic [15:0] b,
                          input logic tb, input logic rnd, input logic la, input logic lb);
    a_in = a; a_tc = ta; tb_b = b; b_tc = tb; rnd_in = rnd;
    ld_a = la; ld_b = lb; oe_lo = 1'b0; tb_b_en = 1'b1;
    @(negedge clk);
    ld_a = 1'b0; ld_b = 1'b0; tb_b_en = 1'b0;
    if (la) begin m_a = a; m_ta = ta; end
    if (lb) begin m_b = b; m_tb = tb; end
    if (la || lb) m_rnd = rnd;
  endtask

  task automatic load_res(input logic lh, input logic ll);
    logic [31:0] r;
    r = ref_word();
    ld_hi = lh; ld_lo = ll;
    @(negedge clk);
    ld_hi = 1'b0; ld_lo = 1'b0;
    if (lh) m_hi = r[31:16];
    if (ll) m_lo = r[15:0];
  endtask

  task automatic expect_out(input logic sel, input string tag);
    logic [31:0] r;
    exp_t e;
    logic [15:0] vh, vl;
    r  = ref_word();
    vh = ft ? r[31:16] : m_hi;
    vl = ft ? r[15:0]  : m_lo;
    msel = sel; oe_hi = 1'b1; oe_lo = 1'b1;
    e.hi = sel ? vl : vh;
    e.lo = vl;
    e.tag = tag;
    sb_q.push_back(e);
    smp = 1'b1;
    @(negedge clk);
    smp = 1'b0; oe_lo = 1'b0;
  endtask

  task automatic full_op(input logic [15:0] a, input logic ta, input logic [15:0] b,
                         input logic tb, input logic rnd, input string tag);
    load_ops(a, ta, b, tb, rnd, 1'b1, 1'b1);
    load_res(1'b1, 1'b1);
    expect_out(1'b0, tag);
  endtask

  initial begin
    logic [15:0] av [3];
    logic [15:0] bv [3];
    av[0] = 16'h8000; bv[0] = 16'hFFFF;
    av[1] = 16'h7FFF; bv[1] = 16'h8001;
    av[2] = 16'h1234; bv[2] = 16'hFEDC;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10: everything reads zero after reset
    expect_out(1'b0, "R10 reset");

    // R3 R5: all sign-mode pairs, both formats, round toggled (R4)
    for (int f = 0; f < 2; f++) begin
      rs = f[0];
      for (int m = 0; m < 4; m++) begin
        for (int k = 0; k < 3; k++) begin
          full_op(av[k], m[1], bv[k], m[0], k[0], "R3 R5 modes/format");
        end
      end
    end

    // R4: round carry into the upper half, full format
    rs = 1'b1;
    full_op(16'h0001, 1'b0, 16'h8000, 1'b0, 1'b1, "R4 round full");
    // R4: round at bit 14 in sign-copy format
    rs = 1'b0;
    full_op(16'h0001, 1'b0, 16'h4000, 1'b0, 1'b1, "R4 round signcopy");
    // R5: most negative squared in sign-copy format
    full_op(16'h8000, 1'b1, 16'h8000, 1'b1, 1'b0, "R5 signcopy extreme");

    // R1 R4: load A only with round set; B and its mode stay
    rs = 1'b1;
    load_ops(16'h00FF, 1'b0, 16'hAAAA, 1'b1, 1'b1, 1'b1, 1'b0);
    load_res(1'b1, 1'b1);
    expect_out(1'b0, "R1 R2 R4 A-only load");
    // R2 R4: load B only, round cleared; A holds although a_in moves
    load_ops(16'h5555, 1'b1, 16'h0F0F, 1'b1, 1'b0, 1'b0, 1'b1);
    load_res(1'b1, 1'b1);
    expect_out(1'b0, "R1 R2 R4 B-only load");

    // R6: only the upper result register loads
    load_ops(16'hC001, 1'b1, 16'h0123, 1'b0, 1'b0, 1'b1, 1'b1);
    load_res(1'b1, 1'b0);
    expect_out(1'b0, "R6 upper only");
    // R6: now only the lower one
    load_ops(16'h0FFF, 1'b0, 16'h7001, 1'b1, 1'b1, 1'b1, 1'b1);
    load_res(1'b0, 1'b1);
    expect_out(1'b0, "R6 lower only");

    // R7: feed-through shows new operands without any result load
    ft = 1'b1;
    load_ops(16'hFFFE, 1'b1, 16'h0003, 1'b1, 1'b0, 1'b1, 1'b1);
    expect_out(1'b0, "R7 feed-through");
    rs = 1'b0;
    expect_out(1'b1, "R7 R8 feed-through signcopy lower");
    rs = 1'b1;
    // R7: clearing ft returns the held register contents
    ft = 1'b0;
    expect_out(1'b0, "R7 registers after bypass");

    // R8: upper port carries the lower half when msel=1
    full_op(16'h4321, 1'b0, 16'h00A5, 1'b0, 1'b0, "R8 msel upper");
    expect_out(1'b1, "R8 msel lower");

    // R9: bus released with oe_lo=0 lets B load, then drives lower half again
    full_op(16'h0002, 1'b0, 16'h9999, 1'b0, 1'b0, "R9 bus turnaround");

    repeat (4) @(negedge clk);
    if (sb_q.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R8 leftover act=%0d exp=0", sb_q.size());
    end
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R3 watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule